// File: doc/BRIEF.md
# Process Data Cycle Sequencer with Safe-State Watchdog

This block sequences input/output refresh cycles for a host. The host writes a byte to the request register. The value of that byte does not matter: the write itself starts a cycle on an external bus engine. When the engine signals that it has finished, the block copies the current request byte into the ready byte. The host knows a cycle is complete when the ready byte equals the value it wrote.

While a cycle runs, the block measures its length in microseconds. If the host writes a new request before the running cycle has finished, the write is counted as an overrun. It is not queued.

Every request write restarts a watchdog that counts in milliseconds. If the host stops requesting cycles, the watchdog expires. The block then raises a one-cycle strobe that tells the output image to go to zero, and it increments an expiry counter. The host can load a new watchdog period at any time, but the new value takes effect only when a node reset is applied. The block also holds two sticky bus error flags that the host reads back in an error byte.

Top module: `pdc_handshake`

## Requirements
- R1: A request write while no cycle is running, or in the same cycle as a completion, stores the written byte in `req_val` and produces a one-clock `eng_start` pulse on the following clock, whatever the byte value.
- R2: `eng_done` while a cycle runs loads `rdy_val` with the request byte held at that moment, visible one clock later. `eng_done` while idle leaves `rdy_val` unchanged.
- R3: The microsecond tick fires once every `CLK_PER_US` clocks. `cyc_time_us` reports the number of microsecond ticks counted between a cycle's start and its completion. It is updated only at completion.
- R4: A request write while a cycle runs, without a completion in that clock, adds one to `ovr_cnt` and does not start a new cycle. The running cycle then completes with the latest request byte.
- R5: A request write arms the watchdog and restarts its count. After `wdt_period_ms` millisecond ticks (one per `US_PER_MS` microsecond ticks) with no further write, `zero_out` pulses for one clock, `wdt_err_cnt` goes up by one, and the watchdog disarms.
- R6: `ovr_cnt` and `wdt_err_cnt` stop at their all-ones value instead of wrapping.
- R7: A period written on `wdt_cfg_ms` with `wdt_cfg_wr` is held as pending. `wdt_period_ms` takes the pending value only on a `node_rst` pulse, which also disarms the watchdog. `node_rst` takes priority over a request write in the same clock.
- R8: `err_byte` bit 0 is the primary bus error and bit 1 is the secondary bus error. Each bit is set by the matching `bus_err_set` bit and cleared by the matching `bus_err_clr` bit, with set winning when both arrive together. Bits 7..2 read 0.
- R9: An active period of 0 disables the watchdog: request writes do not arm it, and `zero_out` never pulses.
- R10: After reset, `req_val`, `rdy_val`, `cyc_time_us`, `ovr_cnt`, `wdt_err_cnt` and `err_byte` are 0, no cycle runs, and `wdt_period_ms` and the pending period equal `WDT_DEFAULT_MS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Host write strobe for the request byte |
| req_wdata | input | DATA_W | Byte written to the request register |
| req_val | output | DATA_W | Current request byte |
| rdy_val | output | DATA_W | Ready byte, an echo of the request byte at completion |
| eng_start | output | 1 | One-clock pulse that starts a bus engine cycle |
| eng_done | input | 1 | Bus engine completion pulse |
| cyc_time_us | output | TIME_W | Length of the last completed cycle, in microseconds |
| ovr_cnt | output | CNT_W | Saturating count of overruns |
| wdt_cfg_wr | input | 1 | Host write strobe for the pending watchdog period |
| wdt_cfg_ms | input | WDT_W | Pending watchdog period, in milliseconds |
| node_rst | input | 1 | Node reset pulse; applies the pending watchdog period |
| wdt_period_ms | output | WDT_W | Active watchdog period |
| wdt_err_cnt | output | CNT_W | Saturating count of watchdog expiries |
| zero_out | output | 1 | One-clock strobe that clears the output image |
| bus_err_set | input | 2 | Sets the error flags (bit 0 primary, bit 1 secondary) |
| bus_err_clr | input | 2 | Clears the error flags |
| err_byte | output | 8 | Error status byte |

## Verification
Most internal faults in this block reach the ports within one clock of the event they disturb:
- A wrong phase bit either starts a cycle that should not start (a stray `eng_start`) or ignores a completion (`rdy_val` does not update).
- A wrong request latch shows up as a wrong echo in `rdy_val` on the clock after `eng_done`.

Some faults show up later:
- A fault in the prescaler or the cycle counter shows only at the next completion, as a changed `cyc_time_us`.
- A fault in the watchdog count shows only at expiry, as a `zero_out` strobe that comes a millisecond too early or too late, or never comes.

The bench compares every output against a reference model on every clock, so each of these faults is caught at the first clock where it becomes visible.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int ERR_PRIMARY_BIT   = 0;
    localparam int ERR_SECONDARY_BIT = 1;
    localparam int ERR_FLAGS         = 2;
    localparam int ERR_BYTE_W        = 8;

endpackage

// File: rtl/pdc_tick_gen.sv
module pdc_tick_gen #(
    parameter int CLK_PER_US = 50,
    parameter int US_PER_MS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick,
    output logic ms_tick
);
    localparam int PRE_W = $clog2(CLK_PER_US);
    localparam int USC_W = $clog2(US_PER_MS);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [USC_W-1:0] usc;
    } tick_st_t;

    tick_st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        us_tick = (st_q.pre == PRE_W'(CLK_PER_US - 1));
        ms_tick = us_tick && (st_q.usc == USC_W'(US_PER_MS - 1));
        if (us_tick) begin
            st_d.pre = '0;
            st_d.usc = ms_tick ? '0 : st_q.usc + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_MS_INSIDE_US: assert property (@(posedge clk) disable iff (!rst_n) ms_tick |-> us_tick) else $error("ms tick without us tick"); // R5

endmodule

// File: rtl/pdc_cycle.sv
module pdc_cycle
    import pdc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TIME_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              eng_done,
    output logic              eng_start,
    output logic [DATA_W-1:0] req_val,
    output logic [DATA_W-1:0] rdy_val,
    output logic [TIME_W-1:0] cyc_time_us,
    output logic [CNT_W-1:0]  ovr_cnt
);
    localparam logic [TIME_W-1:0] TIME_MAX = '1;
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

    typedef struct packed {
        phase_e            phase;
        logic              start;
        logic [DATA_W-1:0] req;
        logic [DATA_W-1:0] rdy;
        logic [TIME_W-1:0] run_us;
        logic [TIME_W-1:0] last_us;
        logic [CNT_W-1:0]  ovr;
    } cyc_st_t;

    cyc_st_t st_q, st_d;
    logic    done_ok;
    logic    launch;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        done_ok    = eng_done && (st_q.phase == PH_RUN);
        launch     = req_wr && ((st_q.phase == PH_IDLE) || done_ok);
        if ((st_q.phase == PH_RUN) && us_tick && (st_q.run_us != TIME_MAX))
            st_d.run_us = st_q.run_us + 1'b1;
        if (done_ok) begin
            st_d.rdy     = st_q.req;
            st_d.last_us = st_q.run_us;
            st_d.phase   = PH_IDLE;
        end
        if (req_wr)
            st_d.req = req_wdata;
        if (req_wr && !launch && (st_q.ovr != CNT_MAX))
            st_d.ovr = st_q.ovr + 1'b1;
        if (launch) begin
            st_d.phase  = PH_RUN;
            st_d.run_us = '0;
            st_d.start  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eng_start   = st_q.start;
    assign req_val     = st_q.req;
    assign rdy_val     = st_q.rdy;
    assign cyc_time_us = st_q.last_us;
    assign ovr_cnt     = st_q.ovr;

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) eng_start |-> $past(req_wr)) else $error("start without write"); // R1
    AST_RDY_ECHO: assert property (@(posedge clk) disable iff (!rst_n) (eng_done && st_q.phase == PH_RUN) |=> rdy_val == $past(st_q.req)) else $error("ready echo wrong"); // R2
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (st_q.phase == PH_IDLE) |=> rdy_val == $past(rdy_val)) else $error("ready moved while idle"); // R2
    AST_OVR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (ovr_cnt == CNT_MAX) |=> (ovr_cnt == CNT_MAX)) else $error("overrun count wrapped"); // R6
    AST_OVR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ovr_cnt >= $past(ovr_cnt)) else $error("overrun count dropped"); // R4

endmodule

// File: rtl/pdc_wdog.sv
module pdc_wdog #(
    parameter int WDT_W          = 16,
    parameter int CNT_W          = 8,
    parameter int WDT_DEFAULT_MS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             req_wr,
    input  logic             cfg_wr,
    input  logic [WDT_W-1:0] cfg_ms,
    input  logic             node_rst,
    output logic [WDT_W-1:0] period_ms,
    output logic [CNT_W-1:0] err_cnt,
    output logic             zero_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [WDT_W-1:0] DEF_MS  = WDT_W'(WDT_DEFAULT_MS);

    typedef struct packed {
        logic [WDT_W-1:0] pend;
        logic [WDT_W-1:0] period;
        logic             armed;
        logic [WDT_W-1:0] cnt;
        logic [CNT_W-1:0] err;
        logic             zero;
    } wd_st_t;

    wd_st_t         st_q, st_d;
    logic [WDT_W:0] cnt_inc;
    logic           expire;

    always_comb begin
        st_d      = st_q;
        st_d.zero = 1'b0;
        cnt_inc   = {1'b0, st_q.cnt} + 1'b1;
        expire    = 1'b0;
        if (node_rst) begin
            st_d.period = st_q.pend;
            st_d.armed  = 1'b0;
            st_d.cnt    = '0;
        end else if (req_wr) begin
            st_d.armed = (st_q.period != '0);
            st_d.cnt   = '0;
        end else if (st_q.armed && ms_tick) begin
            if (cnt_inc >= {1'b0, st_q.period}) begin
                expire     = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = cnt_inc[WDT_W-1:0];
            end
        end
        if (cfg_wr)
            st_d.pend = cfg_ms;
        if (expire) begin
            st_d.zero = 1'b1;
            if (st_q.err != CNT_MAX)
                st_d.err = st_q.err + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.pend   <= DEF_MS;
            st_q.period <= DEF_MS;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_ms = st_q.period;
    assign err_cnt   = st_q.err;
    assign zero_out  = st_q.zero;

    AST_EXPIRY_COUNTS: assert property (@(posedge clk) disable iff (!rst_n) (zero_out && $past(err_cnt) != CNT_MAX) |-> err_cnt == $past(err_cnt) + 1'b1) else $error("expiry not counted"); // R5
    AST_WDT_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (err_cnt == CNT_MAX) |=> (err_cnt == CNT_MAX)) else $error("expiry count wrapped"); // R6
    AST_PERIOD_ONLY_ON_NODE_RST: assert property (@(posedge clk) disable iff (!rst_n) !node_rst |=> period_ms == $past(period_ms)) else $error("period moved without node reset"); // R7
    AST_ZERO_PERIOD_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (period_ms == '0 && !$past(node_rst)) |-> !zero_out) else $error("disabled watchdog fired"); // R9

endmodule

// File: rtl/pdc_handshake.sv
module pdc_handshake
    import pdc_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int TIME_W         = 16,
    parameter int CNT_W          = 8,
    parameter int WDT_W          = 16,
    parameter int CLK_PER_US     = 50,
    parameter int US_PER_MS      = 1000,
    parameter int WDT_DEFAULT_MS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_val,
    output logic [DATA_W-1:0] rdy_val,
    output logic              eng_start,
    input  logic              eng_done,
    output logic [TIME_W-1:0] cyc_time_us,
    output logic [CNT_W-1:0]  ovr_cnt,
    input  logic              wdt_cfg_wr,
    input  logic [WDT_W-1:0]  wdt_cfg_ms,
    input  logic              node_rst,
    output logic [WDT_W-1:0]  wdt_period_ms,
    output logic [CNT_W-1:0]  wdt_err_cnt,
    output logic              zero_out,
    input  logic [1:0]        bus_err_set,
    input  logic [1:0]        bus_err_clr,
    output logic [7:0]        err_byte
);
    logic us_tick;
    logic ms_tick;

    pdc_tick_gen #(
        .CLK_PER_US (CLK_PER_US),
        .US_PER_MS  (US_PER_MS)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .ms_tick (ms_tick)
    );

    pdc_cycle #(
        .DATA_W (DATA_W),
        .TIME_W (TIME_W),
        .CNT_W  (CNT_W)
    ) u_cycle (
        .clk         (clk),
        .rst_n       (rst_n),
        .us_tick     (us_tick),
        .req_wr      (req_wr),
        .req_wdata   (req_wdata),
        .eng_done    (eng_done),
        .eng_start   (eng_start),
        .req_val     (req_val),
        .rdy_val     (rdy_val),
        .cyc_time_us (cyc_time_us),
        .ovr_cnt     (ovr_cnt)
    );

    pdc_wdog #(
        .WDT_W          (WDT_W),
        .CNT_W          (CNT_W),
        .WDT_DEFAULT_MS (WDT_DEFAULT_MS)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .req_wr    (req_wr),
        .cfg_wr    (wdt_cfg_wr),
        .cfg_ms    (wdt_cfg_ms),
        .node_rst  (node_rst),
        .period_ms (wdt_period_ms),
        .err_cnt   (wdt_err_cnt),
        .zero_out  (zero_out)
    );

    logic [ERR_FLAGS-1:0] err_d, err_q;

    always_comb begin
        err_d = (err_q & ~bus_err_clr) | bus_err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    always_comb begin
        err_byte                    = '0;
        err_byte[ERR_PRIMARY_BIT]   = err_q[0];
        err_byte[ERR_SECONDARY_BIT] = err_q[1];
    end

    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (err_byte[1:0] & $past(bus_err_set)) == $past(bus_err_set)) else $error("error set lost"); // R8

endmodule

// File: tb/pdc_handshake_tb.sv
module pdc_handshake_tb;
    localparam int P    = 4;
    localparam int U    = 5;
    localparam int DEFW = 3;
    localparam int CMAX = 15;
    localparam int TMAX = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  req_val, rdy_val;
    logic        eng_start;
    logic        eng_done = 1'b0;
    logic [15:0] cyc_time_us;
    logic [3:0]  ovr_cnt;
    logic        wdt_cfg_wr = 1'b0;
    logic [15:0] wdt_cfg_ms = '0;
    logic        node_rst = 1'b0;
    logic [15:0] wdt_period_ms;
    logic [3:0]  wdt_err_cnt;
    logic        zero_out;
    logic [1:0]  bus_err_set = '0;
    logic [1:0]  bus_err_clr = '0;
    logic [7:0]  err_byte;

    always #10 clk = ~clk;

    pdc_handshake #(
        .DATA_W(8), .TIME_W(16), .CNT_W(4), .WDT_W(16),
        .CLK_PER_US(P), .US_PER_MS(U), .WDT_DEFAULT_MS(DEFW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_wdata(req_wdata),
        .req_val(req_val), .rdy_val(rdy_val), .eng_start(eng_start), .eng_done(eng_done),
        .cyc_time_us(cyc_time_us), .ovr_cnt(ovr_cnt), .wdt_cfg_wr(wdt_cfg_wr),
        .wdt_cfg_ms(wdt_cfg_ms), .node_rst(node_rst), .wdt_period_ms(wdt_period_ms),
        .wdt_err_cnt(wdt_err_cnt), .zero_out(zero_out), .bus_err_set(bus_err_set),
        .bus_err_clr(bus_err_clr), .err_byte(err_byte)
    );

    int total = 0;
    int bad = 0;
    int zero_seen = 0;
    int start_seen = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, behavioural integers
    int m_pre, m_us, m_busy, m_req, m_rdy, m_cnt, m_time, m_ovr, m_start;
    int m_pend, m_per, m_arm, m_wc, m_werr, m_zero, m_err;
    bit ust, mst, dn, st, ex;
    int b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_us = 0; m_busy = 0; m_req = 0; m_rdy = 0; m_cnt = 0;
            m_time = 0; m_ovr = 0; m_start = 0; m_pend = DEFW; m_per = DEFW;
            m_arm = 0; m_wc = 0; m_werr = 0; m_zero = 0; m_err = 0;
        end else begin
            ust = (m_pre == P - 1);
            mst = ust && (m_us == U - 1);
            m_pre = ust ? 0 : m_pre + 1;
            if (ust) m_us = mst ? 0 : m_us + 1;
            b0 = m_busy;
            dn = eng_done && (b0 != 0);
            st = req_wr && ((b0 == 0) || dn);
            if (b0 != 0 && ust && m_cnt < TMAX) m_cnt++;
            if (dn) begin m_rdy = m_req; m_time = (ust && m_cnt > 0) ? m_time : m_time; end
            if (dn) begin m_time = m_cnt - ((ust && m_cnt < TMAX + 1 && b0 != 0 && m_cnt > 0) ? 1 : 0); m_busy = 0; end
            if (req_wr && !st && m_ovr < CMAX) m_ovr++;
            if (req_wr) m_req = req_wdata;
            m_start = st;
            if (st) begin m_busy = 1; m_cnt = 0; end
            ex = 0;
            if (node_rst) begin m_per = m_pend; m_arm = 0; m_wc = 0; end
            else if (req_wr) begin m_arm = (m_per != 0); m_wc = 0; end
            else if (m_arm != 0 && mst) begin
                if (m_wc + 1 >= m_per) begin ex = 1; m_arm = 0; m_wc = 0; end
                else m_wc++;
            end
            if (wdt_cfg_wr) m_pend = wdt_cfg_ms;
            m_zero = ex;
            if (ex && m_werr < CMAX) m_werr++;
            m_err = (m_err & ~bus_err_clr) | bus_err_set;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(eng_start == m_start[0], "R1 eng_start", eng_start, m_start);
            chk(req_val == m_req, "R1 req_val", req_val, m_req);
            chk(rdy_val == m_rdy, "R2 rdy_val", rdy_val, m_rdy);
            chk(cyc_time_us == m_time, "R3 cyc_time_us", cyc_time_us, m_time);
            chk(ovr_cnt == m_ovr, "R4 ovr_cnt", ovr_cnt, m_ovr);
            chk(zero_out == m_zero[0], "R5 zero_out", zero_out, m_zero);
            chk(wdt_err_cnt == m_werr, "R5 wdt_err_cnt", wdt_err_cnt, m_werr);
            chk(wdt_period_ms == m_per, "R7 wdt_period_ms", wdt_period_ms, m_per);
            chk(err_byte == m_err, "R8 err_byte", err_byte, m_err);
            if (zero_out) zero_seen++;
            if (eng_start) start_seen++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_req(input logic [7:0] v);
        req_wr = 1'b1; req_wdata = v; @(negedge clk); req_wr = 1'b0;
    endtask
    task automatic done_pulse();
        eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    endtask
    task automatic cfg_and_nrst(input logic [15:0] ms);
        wdt_cfg_wr = 1'b1; wdt_cfg_ms = ms; @(negedge clk); wdt_cfg_wr = 1'b0;
        node_rst = 1'b1; @(negedge clk); node_rst = 1'b0;
    endtask

    initial begin
        int s0, z0;
        idle(3);
        chk(rdy_val == 0 && req_val == 0 && ovr_cnt == 0 && err_byte == 0, "R10 reset zeros", rdy_val, 0);
        chk(wdt_period_ms == DEFW, "R10 reset period", wdt_period_ms, DEFW);
        rst_n = 1'b1;
        idle(2);
        // R1 / R2 basic handshake
        wr_req(8'h5A);
        chk(eng_start == 1'b1, "R1 start pulse", eng_start, 1);
        idle(3); done_pulse();
        chk(rdy_val == 8'h5A, "R2 echo", rdy_val, 8'h5A);
        done_pulse(); idle(1);
        chk(rdy_val == 8'h5A, "R2 idle done ignored", rdy_val, 8'h5A);
        // R3 timing
        wr_req(8'h00); idle(40); done_pulse();
        chk(cyc_time_us >= 9 && cyc_time_us <= 11, "R3 cycle length", cyc_time_us, 10);
        // R4 overrun
        s0 = start_seen;
        wr_req(8'h01); idle(2); wr_req(8'h66); idle(1); wr_req(8'h77); idle(2); done_pulse();
        chk(rdy_val == 8'h77, "R4 latest reported", rdy_val, 8'h77);
        chk(ovr_cnt == 2, "R4 overrun count", ovr_cnt, 2);
        chk(start_seen - s0 == 1, "R4 no queued start", start_seen - s0, 1);
        // R1 write coincident with completion
        wr_req(8'h10); idle(2);
        eng_done = 1'b1; req_wr = 1'b1; req_wdata = 8'h11; @(negedge clk);
        eng_done = 1'b0; req_wr = 1'b0;
        chk(eng_start == 1'b1 && rdy_val == 8'h10, "R1 restart on completion", eng_start, 1);
        idle(2); done_pulse();
        // R6 overrun saturation
        wr_req(8'h20);
        for (int i = 0; i < 20; i++) wr_req(8'(i));
        chk(ovr_cnt == CMAX, "R6 overrun saturates", ovr_cnt, CMAX);
        done_pulse();
        // R5 expiry
        z0 = zero_seen;
        idle(120);
        chk(zero_seen - z0 == 1, "R5 single expiry", zero_seen - z0, 1);
        chk(wdt_err_cnt == 1, "R5 expiry count", wdt_err_cnt, 1);
        // R5 kept alive
        z0 = zero_seen;
        for (int i = 0; i < 8; i++) begin wr_req(8'(i)); idle(4); done_pulse(); idle(24); end
        chk(zero_seen == z0, "R5 refreshed no expiry", zero_seen - z0, 0);
        idle(100);
        // R7 pending period
        wdt_cfg_wr = 1'b1; wdt_cfg_ms = 16'd1; @(negedge clk); wdt_cfg_wr = 1'b0;
        idle(3);
        chk(wdt_period_ms == DEFW, "R7 pending not active", wdt_period_ms, DEFW);
        node_rst = 1'b1; @(negedge clk); node_rst = 1'b0;
        chk(wdt_period_ms == 1, "R7 applied on node reset", wdt_period_ms, 1);
        // R6 expiry saturation
        for (int i = 0; i < 16; i++) begin wr_req(8'(i)); idle(2); done_pulse(); idle(30); end
        chk(wdt_err_cnt == CMAX, "R6 expiry saturates", wdt_err_cnt, CMAX);
        // R9 disabled watchdog
        cfg_and_nrst(16'd0);
        z0 = zero_seen;
        wr_req(8'hAA); idle(2); done_pulse(); idle(200);
        chk(zero_seen == z0, "R9 disabled", zero_seen - z0, 0);
        // R8 error flags
        bus_err_set = 2'b01; @(negedge clk); bus_err_set = 2'b00;
        chk(err_byte == 8'h01, "R8 primary set", err_byte, 1);
        bus_err_set = 2'b10; bus_err_clr = 2'b11; @(negedge clk);
        bus_err_set = 2'b00; bus_err_clr = 2'b00;
        chk(err_byte == 8'h02, "R8 set wins, clear other", err_byte, 2);
        bus_err_clr = 2'b10; @(negedge clk); bus_err_clr = 2'b00;
        chk(err_byte == 8'h00, "R8 cleared", err_byte, 0);
        idle(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R1 run hung actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule